// File: doc/BRIEF.md
# Two-Point-Lead Match Judge

This block referees a two-player contest one round per clock cycle. A single input bit says which player took the round. The block keeps no running tallies. It tracks only how far one player is ahead of the other, within a window of one point either way. When one side moves two points clear, it raises a win flag for one cycle, and a second output names the winner.

In the cycle after a win, the block is already judging a fresh match. The round presented during the win cycle is scored as the opening round of that new match. Both outputs are pure functions of the stored state, so they change only at a clock edge.

A user drives one score bit per cycle. The user reads the flag and the winner bit after each edge. The user may restart the contest at any time with the synchronous reset.

Top module: `match_lead_judge`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block returns to the level-score condition. After that edge `winFlag` is 0 and `winnerSide` is 0, and this holds even when reset arrives in the middle of a match.
- R2: A `scoreBit` value of 0 credits the round to the first player, and a value of 1 credits it to the second player.
- R3: `winFlag` becomes 1 right after the edge that samples the round giving one player a lead of exactly two points. It is 0 after every other edge.
- R4: While `winFlag` is 1, `winnerSide` is 0 if the first player won and 1 if the second player won.
- R5: While `winFlag` is 0, `winnerSide` is driven to 0.
- R6: `winFlag` stays high for exactly one cycle. The round sampled at the end of a win cycle counts as the opening round of a new match, starting from a level score.
- R7: Only the point difference matters. Any stretch of rounds that alternate between players never produces a win, however long it lasts.
- R8: The outputs depend only on the stored state. They change only at rising clock edges, never in response to `scoreBit` between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one scoring round per cycle |
| rst | input | 1 | Synchronous, active-high restart to a level score |
| scoreBit | input | 1 | Round result: 0 = first player scored, 1 = second player scored |
| winFlag | output | 1 | High for one cycle when a winner has been decided |
| winnerSide | output | 1 | Winner identity while `winFlag` is high, otherwise 0 |

## Verification
The bench sweeps every 8-round score sequence from reset and compares both outputs after each edge against an arithmetic lead counter. This catches a design that declares a win at a one-point lead, or that waits for a third point. It also catches one that swaps the winner. The sweep covers sequences that win on consecutive matches, so a design that holds the flag for two cycles fails, and so does one that discards the round taken during the win cycle. Directed runs cover long alternating sequences, which must never win, and a reset issued from a one-ahead state. A design that ignored reset mid-match would then win one round too early. Inputs are also toggled between edges to show that neither output follows them.

// File: rtl/judge_pkg.sv
package judge_pkg;

  localparam int StateWidth = 3;

  typedef enum logic [StateWidth-1:0] {
    LEVEL      = 3'd0,
    FIRST_UP   = 3'd1,
    SECOND_UP  = 3'd2,
    FIRST_WON  = 3'd3,
    SECOND_WON = 3'd4
  } matchState_t;

  typedef struct packed {
    logic declareFirst;
    logic declareSecond;
  } winStrobe_t;

  function automatic matchState_t openingRound(input logic secondScored);
    return secondScored ? SECOND_UP : FIRST_UP;
  endfunction

endpackage

// File: rtl/judge_ctrl.sv
module judge_ctrl
  import judge_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       scoreBit,
  output winStrobe_t strobes
);

  matchState_t stateQ;
  matchState_t stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      FIRST_UP:  stateD = scoreBit ? LEVEL : FIRST_WON;
      SECOND_UP: stateD = scoreBit ? SECOND_WON : LEVEL;
      LEVEL, FIRST_WON, SECOND_WON: stateD = openingRound(scoreBit);
      default:   stateD = LEVEL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= LEVEL;
    else     stateQ <= stateD;
  end

  always_comb begin
    strobes.declareFirst  = (stateQ == FIRST_WON);
    strobes.declareSecond = (stateQ == SECOND_WON);
  end

  // R1
  reset_level_chk: assert property (@(posedge clk) rst |=> stateQ == LEVEL);

  // R3
  first_clinch_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == FIRST_UP && !scoreBit) |=> stateQ == FIRST_WON);

  // R3
  second_clinch_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == SECOND_UP && scoreBit) |=> stateQ == SECOND_WON);

  // R6
  single_win_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == FIRST_WON || stateQ == SECOND_WON) |=>
      (stateQ == FIRST_UP || stateQ == SECOND_UP));

  // R7
  no_win_from_level_chk: assert property (@(posedge clk) disable iff (rst)
    stateQ == LEVEL |=> (stateQ != FIRST_WON && stateQ != SECOND_WON));

  // R2
  credit_direction_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == LEVEL && scoreBit) |=> stateQ == SECOND_UP);

endmodule

// File: rtl/judge_outs.sv
module judge_outs
  import judge_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  winStrobe_t strobes,
  output logic       winFlag,
  output logic       winnerSide
);

  always_comb begin
    winFlag    = strobes.declareFirst | strobes.declareSecond;
    winnerSide = strobes.declareSecond;
  end

  // R4
  one_winner_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.declareFirst, strobes.declareSecond}));

  // R5
  quiet_side_chk: assert property (@(posedge clk) disable iff (rst)
    !winFlag |-> !winnerSide);

  // R6
  flag_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    winFlag |=> !winFlag);

endmodule

// File: rtl/match_lead_judge.sv
module match_lead_judge
  import judge_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic scoreBit,
  output logic winFlag,
  output logic winnerSide
);

  winStrobe_t strobes;

  judge_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .scoreBit (scoreBit),
    .strobes  (strobes)
  );

  judge_outs i_outs (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .winFlag    (winFlag),
    .winnerSide (winnerSide)
  );

endmodule

// File: tb/test_match_lead_judge.sv
`timescale 1ns/1ps
module test_match_lead_judge;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scoreBit = 1'b0;
  logic winFlag;
  logic winnerSide;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model
  int  lead = 0;
  bit  refWon = 1'b0;
  bit  refSecond = 1'b0;

  always #5 clk = ~clk;

  match_lead_judge i_match_lead_judge (
    .clk(clk), .rst(rst), .scoreBit(scoreBit),
    .winFlag(winFlag), .winnerSide(winnerSide)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    lead = 0; refWon = 1'b0; refSecond = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    modelReset();
    // R1
    chk("R1", winFlag, 1'b0);
    chk("R1", winnerSide, 1'b0);
  endtask

  // one round: input driven at negedge, outputs checked at the following negedge
  task automatic playRound(input bit x, input string flagTag);
    bit wasWon;
    wasWon = refWon;
    scoreBit = x;
    if (refWon) begin lead = 0; refWon = 1'b0; end
    lead += x ? -1 : 1;
    if (lead == 2)  begin refWon = 1'b1; refSecond = 1'b0; end
    if (lead == -2) begin refWon = 1'b1; refSecond = 1'b1; end
    @(negedge clk);
    if (wasWon) chk("R6", winFlag, refWon);
    else        chk(flagTag, winFlag, refWon);
    if (refWon) chk("R4", winnerSide, refSecond);
    else        chk("R5", winnerSide, 1'b0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();

    // R2: two first-player rounds win for the first player, two second-player rounds for the second
    playRound(1'b0, "R2"); playRound(1'b0, "R2");
    chk("R2", winnerSide, 1'b0);
    doReset();
    playRound(1'b1, "R2"); playRound(1'b1, "R2");
    chk("R2", winnerSide, 1'b1);

    // R3 / R4 / R5 / R6: every 8-round sequence from reset
    for (int seq = 0; seq < 256; seq++) begin
      doReset();
      for (int b = 0; b < 8; b++) playRound(seq[b], "R3");
    end

    // R7: long alternating run never wins
    doReset();
    for (int i = 0; i < 40; i++) playRound(i[0], "R7");
    for (int i = 0; i < 40; i++) playRound(~i[0], "R7");

    // R1: reset from a one-ahead state, then one more round must not win
    doReset();
    playRound(1'b0, "R3");
    doReset();
    playRound(1'b0, "R1");

    // R8: toggling the input between edges leaves outputs unchanged
    doReset();
    playRound(1'b1, "R3");
    playRound(1'b1, "R3");
    for (int k = 0; k < 3; k++) begin
      #1 scoreBit = ~scoreBit;
      chk("R8", winFlag, 1'b1);
      chk("R8", winnerSide, 1'b1);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule